// File: doc/BRIEF.md
# Receive FIFO with hysteretic RTS flow control

This block buffers received bytes between a serial deserializer and the host. The deserializer pushes each completed byte into a 64-entry, 8-bit-wide first-in first-out store. The host pops bytes in arrival order. The block reports its current occupancy, plus full and empty indications. A sticky overrun flag records any byte that was lost because the store was full.

The block also drives an active-low request-to-send line (`rts_n`), so that the remote transmitter can be throttled without host involvement. In automatic mode the line is released (driven high) once the occupancy reaches a programmable halt level. It is driven low again only after the occupancy has drained to a lower, separately programmed resume level. Between the two levels the line keeps its previous state, which gives hysteresis.

The remote sender may already be shifting out one more byte when it sees the line released. For this reason the store keeps accepting writes above the halt level for as long as space remains. When this line is wired to the clear-to-send input of a transmitter that honours it, the receiver never overruns. With automatic mode off, the line follows a host-written bit.

Top module: `rx_fifo_rts`

## Requirements
- R1: While `rst` is high and in the cycle after it falls, `level` is 0, `empty` is 1, `full` is 0, `overrun` is 0 and `rts_n` is 1.
- R2: Bytes are returned in the order they were accepted. A pop requested with `rd_en` in one cycle updates `rd_data` at the following clock edge.
- R3: `level` is the number of accepted writes minus accepted reads, in the range 0 to 64. `full` is 1 exactly at 64 and `empty` is 1 exactly at 0. A read while empty is ignored: `level` stays 0 and `rd_data` keeps its value.
- R4: A write while full with no read in the same cycle is dropped. `level` stays 64, the stored bytes are unchanged and `overrun` becomes 1 and stays 1.
- R5: A one-cycle `ovr_clr` pulse clears `overrun`. A dropped write in the same cycle takes priority and keeps the flag set.
- R6: A write and a read in the same cycle leave `level` unchanged. This holds even when the store is full, and in that case no overrun is flagged and the new byte is queued behind the remaining ones.
- R7: With `auto_rts_en`=1 and a valid configuration, `rts_n` becomes 1 at the clock edge after the cycle in which `level` >= `cfg_halt`. A valid configuration means `cfg_halt` is not 0 and `cfg_resume` < `cfg_halt`. This is one cycle after the write that raised `level`.
- R8: In the same mode, `rts_n` becomes 0 at the clock edge after a cycle in which `level` <= `cfg_resume`. While `level` lies strictly between the two levels, `rts_n` holds its previous value.
- R9: Writes above the halt level are accepted while `level` < 64.
- R10: With `auto_rts_en`=1 and an invalid configuration (`cfg_halt`=0 or `cfg_resume` >= `cfg_halt`), `rts_n` is 0 from the next clock edge.
- R11: With `auto_rts_en`=0, `rts_n` equals the inverse of `manual_rts`, sampled one cycle earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Push request from the deserializer |
| wr_data | input | 8 | Byte to push |
| rd_en | input | 1 | Pop request from the host |
| rd_data | output | 8 | Popped byte, registered |
| level | output | 7 | Current occupancy, 0 to 64 |
| full | output | 1 | Occupancy equals 64 |
| empty | output | 1 | Occupancy equals 0 |
| overrun | output | 1 | Sticky flag: a write was dropped |
| ovr_clr | input | 1 | Clears the overrun flag |
| auto_rts_en | input | 1 | 1 selects automatic RTS control |
| manual_rts | input | 1 | Host RTS bit used in manual mode, 1 requests data |
| cfg_halt | input | 7 | Occupancy at which RTS is released |
| cfg_resume | input | 7 | Occupancy at or below which RTS is asserted again |
| rts_n | output | 1 | Active-low request to send |

## Verification
The bound checker watches every cycle for the following:
- occupancy steps of more than one, and occupancy above 64;
- a simultaneous push and pop that changes the count;
- a dropped write that fails to set the overrun flag;
- the RTS pin disobeying the halt level, the resume level, an invalid configuration or manual mode, one cycle later.

Only the directed scenarios can show the rest:
- that bytes come back in order;
- that a dropped byte never appears in the data;
- that the pin holds its state inside the hysteresis band;
- that bytes arriving after the halt level are still stored.

// File: rtl/rxf_pkg.sv
package rxf_pkg;
  typedef enum logic [1:0] {
    RTS_MANUAL = 2'd0,
    RTS_AUTO   = 2'd1,
    RTS_FORCED = 2'd2
  } rts_mode_e;

  function automatic rts_mode_e pick_mode(input logic auto_en, input logic cfg_ok);
    if (!auto_en) return RTS_MANUAL;
    if (!cfg_ok)  return RTS_FORCED;
    return RTS_AUTO;
  endfunction
endpackage

// File: rtl/rxf_store.sv
module rxf_store #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 64,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              we,
  input  logic [AW-1:0]     waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              re,
  input  logic [AW-1:0]     raddr,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  // read-first: on a same-address collision the old entry is returned
  always_ff @(posedge clk) begin
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/rxf_ctrl.sv
module rxf_ctrl #(
  parameter int DEPTH  = 64,
  localparam int AW    = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic             rd_en,
  input  logic             ovr_clr,
  output logic             wr_ok,
  output logic             rd_ok,
  output logic [AW-1:0]    wr_ptr,
  output logic [AW-1:0]    rd_ptr,
  output logic [CNT_W-1:0] count,
  output logic             full,
  output logic             empty,
  output logic             overrun
);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

  assign full  = (count == FULL_CNT);
  assign empty = (count == '0);
  assign rd_ok = rd_en && !empty;
  assign wr_ok = wr_en && (!full || rd_ok);

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr  <= '0;
      rd_ptr  <= '0;
      count   <= '0;
      overrun <= 1'b0;
    end else begin
      if (wr_ok) wr_ptr <= wr_ptr + 1'b1;
      if (rd_ok) rd_ptr <= rd_ptr + 1'b1;
      if (wr_ok && !rd_ok)      count <= count + 1'b1;
      else if (rd_ok && !wr_ok) count <= count - 1'b1;
      if (wr_en && !wr_ok)      overrun <= 1'b1;
      else if (ovr_clr)         overrun <= 1'b0;
    end
  end
endmodule

// File: rtl/rxf_rts.sv
module rxf_rts
  import rxf_pkg::*;
#(
  parameter int CNT_W = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] count,
  input  logic [CNT_W-1:0] halt_lvl,
  input  logic [CNT_W-1:0] resume_lvl,
  input  logic             auto_en,
  input  logic             manual_req,
  output logic             rts_n
);
  logic      cfg_ok;
  rts_mode_e mode;
  logic      req_q;
  logic      req_d;

  assign cfg_ok = (halt_lvl != '0) && (resume_lvl < halt_lvl);
  assign mode   = pick_mode(auto_en, cfg_ok);

  always_comb begin
    req_d = req_q;
    unique case (mode)
      RTS_MANUAL: req_d = manual_req;
      RTS_FORCED: req_d = 1'b1;
      RTS_AUTO: begin
        if (count >= halt_lvl)        req_d = 1'b0;
        else if (count <= resume_lvl) req_d = 1'b1;
      end
      default: req_d = 1'b1;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) req_q <= 1'b0;
    else     req_q <= req_d;
  end

  assign rts_n = ~req_q;
endmodule

// File: rtl/rx_fifo_rts.sv
module rx_fifo_rts #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 64,
  localparam int AW    = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  output logic [DATA_W-1:0] rd_data,
  output logic [CNT_W-1:0]  level,
  output logic              full,
  output logic              empty,
  output logic              overrun,
  input  logic              ovr_clr,
  input  logic              auto_rts_en,
  input  logic              manual_rts,
  input  logic [CNT_W-1:0]  cfg_halt,
  input  logic [CNT_W-1:0]  cfg_resume,
  output logic              rts_n
);
  logic          wr_ok, rd_ok;
  logic [AW-1:0] wr_ptr, rd_ptr;

  rxf_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .ovr_clr(ovr_clr),
    .wr_ok(wr_ok), .rd_ok(rd_ok), .wr_ptr(wr_ptr), .rd_ptr(rd_ptr),
    .count(level), .full(full), .empty(empty), .overrun(overrun)
  );

  rxf_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_store (
    .clk(clk), .we(wr_ok), .waddr(wr_ptr), .wdata(wr_data),
    .re(rd_ok), .raddr(rd_ptr), .rdata(rd_data)
  );

  rxf_rts #(.CNT_W(CNT_W)) u_rts (
    .clk(clk), .rst(rst), .count(level), .halt_lvl(cfg_halt),
    .resume_lvl(cfg_resume), .auto_en(auto_rts_en), .manual_req(manual_rts),
    .rts_n(rts_n)
  );
endmodule

// File: rtl/rxf_chk.sv
module rxf_chk #(
  parameter int DEPTH = 64,
  parameter int CNT_W = 7
) (
  input logic             clk,
  input logic             rst,
  input logic             wr_en,
  input logic             rd_en,
  input logic             ovr_clr,
  input logic             auto_rts_en,
  input logic             manual_rts,
  input logic [CNT_W-1:0] cfg_halt,
  input logic [CNT_W-1:0] cfg_resume,
  input logic [CNT_W-1:0] level,
  input logic             full,
  input logic             empty,
  input logic             overrun,
  input logic             rts_n
);
  logic cfg_good;
  assign cfg_good = (cfg_halt != '0) && (cfg_resume < cfg_halt);

  // R1
  reset_state_chk: assert property (@(posedge clk) rst |=> (level == '0 && !overrun && rts_n));
  // R3
  level_range_chk: assert property (@(posedge clk) disable iff (rst) level <= CNT_W'(DEPTH));
  // R3
  level_step_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (level == $past(level) || level == $past(level) + 1'b1 || level == $past(level) - 1'b1));
  // R4
  drop_flag_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && full && !rd_en) |=> (overrun && full));
  // R6
  same_cycle_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && rd_en && !empty) |=> $stable(level));
  // R7
  halt_chk: assert property (@(posedge clk) disable iff (rst)
    (auto_rts_en && cfg_good && level >= cfg_halt) |=> rts_n);
  // R8
  resume_chk: assert property (@(posedge clk) disable iff (rst)
    (auto_rts_en && cfg_good && level <= cfg_resume) |=> !rts_n);
  // R10
  bad_cfg_chk: assert property (@(posedge clk) disable iff (rst)
    (auto_rts_en && !cfg_good) |=> !rts_n);
  // R11
  manual_chk: assert property (@(posedge clk) disable iff (rst)
    !auto_rts_en |=> (rts_n == !$past(manual_rts)));
endmodule

bind rx_fifo_rts rxf_chk #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_chk (.*);

// File: tb/test_rx_fifo_rts.sv
`timescale 1ns/1ps
module test_rx_fifo_rts;
  logic       clk = 0, rst = 1;
  logic       wr_en = 0, rd_en = 0, ovr_clr = 0, auto_rts_en = 0, manual_rts = 0;
  logic [7:0] wr_data = 0, rd_data;
  logic [6:0] level, cfg_halt = 8, cfg_resume = 3;
  logic       full, empty, overrun, rts_n;
  int checks = 0, fails = 0;
  bit done = 0;
  logic [7:0] q[$];

  always #2 clk = ~clk;

  rx_fifo_rts i_rx_fifo_rts (.*);

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic push(logic [7:0] b);
    @(negedge clk); wr_en = 1; wr_data = b;
    if (q.size() < 64) q.push_back(b);
    @(negedge clk); wr_en = 0;
  endtask

  task automatic pop();
    logic [7:0] e;
    @(negedge clk); rd_en = 1;
    @(negedge clk); rd_en = 0;
    if (q.size() > 0) begin e = q.pop_front(); chk("R2 data", rd_data, e); end
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset();
    idle(1);
    chk("R1 level", level, 0); chk("R1 empty", empty, 1); chk("R1 full", full, 0);
    chk("R1 overrun", overrun, 0); chk("R1 rts_n", rts_n, 1);
    @(negedge clk); rst = 0;
    chk("R1 level after", level, 0); chk("R1 rts_n after", rts_n, 1);
  endtask

  task automatic t_order();
    for (int i = 0; i < 5; i++) push(8'h30 + 8'(i));
    chk("R3 level five", level, 5); chk("R3 empty", empty, 0);
    for (int i = 0; i < 5; i++) pop();
    chk("R3 drained", level, 0); chk("R3 empty again", empty, 1);
  endtask

  task automatic t_empty_read();
    logic [7:0] last;
    last = rd_data;
    @(negedge clk); rd_en = 1;
    @(negedge clk); rd_en = 0;
    chk("R3 empty read level", level, 0); chk("R3 empty read data", rd_data, last);
  endtask

  task automatic t_overrun();
    for (int i = 0; i < 64; i++) push(8'(i));
    chk("R3 full", full, 1); chk("R3 level 64", level, 64); chk("R4 no ovr yet", overrun, 0);
    push(8'hEE);
    chk("R4 level kept", level, 64); chk("R4 overrun set", overrun, 1);
    idle(3); chk("R4 sticky", overrun, 1);
    for (int i = 0; i < 64; i++) pop();
    chk("R4 drained", empty, 1);
    @(negedge clk); wr_en = 1; wr_data = 8'h11; ovr_clr = 1;
    q.push_back(8'h11);
    @(negedge clk); wr_en = 0; ovr_clr = 0;
    chk("R5 cleared", overrun, 0);
    pop();
  endtask

  task automatic t_same_cycle();
    for (int i = 0; i < 64; i++) push(8'h80 + 8'(i));
    @(negedge clk); wr_en = 1; rd_en = 1; wr_data = 8'h5A;
    @(negedge clk); wr_en = 0; rd_en = 0;
    chk("R6 level", level, 64); chk("R6 no overrun", overrun, 0);
    chk("R6 oldest out", rd_data, 8'h80);
    void'(q.pop_front()); q.push_back(8'h5A);
    for (int i = 0; i < 64; i++) pop();
    chk("R6 drained", level, 0);
    // simultaneous push and pop mid-fill
    push(8'h01); push(8'h02);
    @(negedge clk); wr_en = 1; rd_en = 1; wr_data = 8'h03;
    @(negedge clk); wr_en = 0; rd_en = 0;
    chk("R6 mid level", level, 2); chk("R6 mid data", rd_data, 8'h01);
    void'(q.pop_front()); q.push_back(8'h03);
    pop(); pop();
  endtask

  task automatic t_hysteresis();
    @(negedge clk); cfg_halt = 8; cfg_resume = 3; auto_rts_en = 1;
    idle(1); chk("R8 empty asserts", rts_n, 0);
    for (int i = 0; i < 7; i++) push(8'h40 + 8'(i));
    idle(1); chk("R8 below halt", rts_n, 0);
    push(8'h47);
    chk("R7 level 8", level, 8); chk("R7 latency", rts_n, 0);
    idle(1); chk("R7 released", rts_n, 1);
    push(8'h48); push(8'h49);
    chk("R9 extra accepted", level, 10); chk("R9 no overrun", overrun, 0);
    for (int i = 0; i < 6; i++) pop();
    idle(1); chk("R8 hold in band", rts_n, 1);
    pop();
    chk("R8 level 3", level, 3); chk("R8 latency", rts_n, 1);
    idle(1); chk("R8 reasserted", rts_n, 0);
    for (int i = 0; i < 3; i++) pop();
  endtask

  task automatic t_bad_cfg();
    for (int i = 0; i < 10; i++) push(8'(i));
    idle(1); chk("R7 above halt", rts_n, 1);
    @(negedge clk); cfg_halt = 0;
    idle(1); chk("R10 halt zero", rts_n, 0);
    @(negedge clk); cfg_halt = 8; cfg_resume = 8;
    idle(1); chk("R10 resume equal", rts_n, 0);
    @(negedge clk); cfg_resume = 3;
    idle(1); chk("R7 valid again", rts_n, 1);
    for (int i = 0; i < 10; i++) pop();
  endtask

  task automatic t_manual();
    @(negedge clk); auto_rts_en = 0; manual_rts = 1;
    chk("R11 before edge", rts_n, 0);
    @(negedge clk); chk("R11 request", rts_n, 0);
    manual_rts = 0;
    chk("R11 delay", rts_n, 0);
    @(negedge clk); chk("R11 release", rts_n, 1);
    for (int i = 0; i < 20; i++) push(8'(i));
    chk("R11 ignores level", rts_n, 1);
    for (int i = 0; i < 20; i++) pop();
  endtask

  initial begin
    t_reset();
    t_order();
    t_empty_read();
    t_overrun();
    t_same_cycle();
    t_hysteresis();
    t_bad_cfg();
    t_manual();
    idle(2);
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule